// File: doc/BRIEF.md
# Receive-Only I2C Slave With Strap-Selected Address

This block is a bus slave for a two-wire serial bus that only ever receives. It samples the clock and data lines with the system clock, cleans each line with a synchronizer and a short majority vote, and finds the bus conditions that frame a message. It shifts in the address byte and compares it with a fixed seven-bit pattern whose lowest bit comes from a strap pin. It answers a write to that address by pulling the data line low for the acknowledge clock.

After a matching write address, every byte the master sends is acknowledged. Each byte is also presented to the downstream logic on a one-cycle strobe, with a flag that marks the first byte of the message. A separate one-cycle pulse marks the stop that ends an addressed message.

The slave never sends data bits. Reads, foreign addresses and single-cycle glitches on either line leave it silent. The data line is driven open-drain: the output means "pull low", and the pad or board logic must turn it into a wired-AND with the bus.

Top module: `i2c_rx_slave`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), sda_pull_low, byte_valid and msg_end are 0 and the slave is idle.
- R2: A falling data line while the clock is high (START) always restarts address reception, including a repeated START in the middle of a byte or message.
- R3: An address byte, sent MSB first, equal to {0111_00, addr_strap, 0} (0x70 with strap 0, 0x72 with strap 1) is acknowledged by holding SDA low during the ninth clock.
- R4: The acknowledge low level is held for the whole high phase of the acknowledge clock and is released after the falling clock edge that ends it.
- R5: An address byte whose upper seven bits differ from the strap-selected pattern gets no acknowledge, and the following bytes get no acknowledge and no byte_valid until the next START.
- R6: An address byte that matches but has bit 0 (read/write) equal to 1 gets no acknowledge, and the slave stays silent until the next START.
- R7: Each data byte after a matching write address is acknowledged and raises byte_valid for exactly one cycle, with byte_data holding the byte (first bit received in bit 7).
- R8: first_byte is 1 with the first data byte after an accepted address and 0 with every later byte of that message.
- R9: A rising data line while the clock is high (STOP) after an accepted write address raises msg_end for one cycle; a STOP after an ignored address does not.
- R10: A pulse of a single system-clock cycle on SCL or SDA has no effect: it creates no condition and no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the bus is oversampled with it |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| addr_strap | input | 1 | Selects bit 1 of the accepted address byte |
| sda_pull_low | output | 1 | 1 pulls the data line low (open-drain acknowledge) |
| byte_valid | output | 1 | One-cycle strobe for each accepted data byte |
| byte_data | output | 8 | Value of the accepted data byte |
| first_byte | output | 1 | Marks the first data byte of a message; valid with byte_valid |
| msg_end | output | 1 | One-cycle pulse on STOP after an addressed write |

## Verification
The address path is driven with both strap settings against both accepted values, the other value, the two read codes and an unrelated address. This separates a wrong strap bit, a missing read/write check and a bad fixed pattern from each other. The data path is tried with all-ones, all-zeros and mixed bytes, so that a stuck or reversed bit shows up, and with a three-byte message that separates the first-byte flag from later bytes. A repeated START inside a byte shows whether the bit count restarts. One-cycle pulses on each line, one placed where an unfiltered START would be seen and one inside a clock low phase, show whether the filter works.

// File: rtl/i2c_rx_pkg.sv
// Shared types for the receive-only bus slave.
// Assumes: the controller uses these state codes only inside the block.
package i2c_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,      // no message for this slave in progress
        RX_ADDR,      // shifting in the address byte
        RX_ACK_ADDR,  // acknowledging the address
        RX_DATA,      // shifting in a data byte
        RX_ACK_DATA,  // acknowledging a data byte
        RX_IGNORE     // not addressed: wait for START or STOP
    } rx_state_t;

endpackage

// File: rtl/i2c_rx_deglitch.sv
// Line cleaner for one bus wire.
// Brings an asynchronous pad level into the clk domain through SYNC_STAGES
// flops, then votes over VOTE_TAPS samples so that a pulse shorter than half
// the window does not change the output.
// Assumes: SYNC_STAGES >= 2, VOTE_TAPS odd and >= 3; idle level is RESET_LEVEL.
module i2c_rx_deglitch #(
    parameter int   SYNC_STAGES = 2,
    parameter int   VOTE_TAPS   = 3,
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(VOTE_TAPS + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_TAPS-1:0]   vote_q;
    logic [CW-1:0]          ones;

    // Synchronizer chain into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= {SYNC_STAGES{RESET_LEVEL}};
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
    end

    // Sample window for the majority vote.
    always_ff @(posedge clk) begin
        if (!rst_n) vote_q <= {VOTE_TAPS{RESET_LEVEL}};
        else        vote_q <= {vote_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
    end

    // Count the high samples in the window.
    always_comb begin
        ones = '0;
        for (int i = 0; i < VOTE_TAPS; i++) ones = ones + CW'(vote_q[i]);
    end

    // Registered majority decision.
    always_ff @(posedge clk) begin
        if (!rst_n) line_o <= RESET_LEVEL;
        else        line_o <= (ones > CW'(VOTE_TAPS / 2));
    end

    AST_VOTE_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (vote_q == {VOTE_TAPS{1'b1}}) |=> line_o);            // R10
    AST_VOTE_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (vote_q == {VOTE_TAPS{1'b0}}) |=> !line_o);           // R10

endmodule

// File: rtl/i2c_rx_events.sv
// Bus event finder.
// Compares the cleaned lines with their values one cycle earlier and reports
// clock edges and the START / STOP conditions (data edge while clock is high).
// Assumes: inputs are already synchronous and filtered; both idle high.
module i2c_rx_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    // Previous-cycle copies of the cleaned lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Edge and condition decode; a data edge only counts while clock stays high.
    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        start_det = scl_f & scl_q & sda_q & ~sda_f;
        stop_det  = scl_f & scl_q & ~sda_q & sda_f;
    end

endmodule

// File: rtl/i2c_rx_ctrl.sv
// Receive controller.
// Counts bits on rising clock edges, decides on the address, drives the
// acknowledge from the falling edge after the last bit to the falling edge that
// ends the acknowledge clock, and hands each data byte downstream.
// Assumes: one event per cycle from i2c_rx_events; START wins over everything.
module i2c_rx_ctrl
    import i2c_rx_pkg::*;
#(
    parameter int                 BYTE_BITS  = 8,
    parameter logic [BYTE_BITS-3:0] ADDR_FIXED = 6'b011100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_high,
    input  logic                 sda_bit,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 start_det,
    input  logic                 stop_det,
    input  logic                 addr_strap,
    output logic                 sda_pull_low,
    output logic                 byte_valid,
    output logic [BYTE_BITS-1:0] byte_data,
    output logic                 first_byte,
    output logic                 msg_end
);
    localparam int CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);

    rx_state_t            state;
    logic [CNT_W-1:0]     bit_cnt;
    logic [BYTE_BITS-1:0] shreg;
    logic                 first_pend;
    logic                 addr_hit;
    logic                 addressed;

    // Address compare: fixed upper bits, strap bit, write direction.
    always_comb begin
        addr_hit  = (shreg[BYTE_BITS-1:1] == {ADDR_FIXED, addr_strap}) && !shreg[0];
        addressed = (state == RX_ACK_ADDR) || (state == RX_DATA) || (state == RX_ACK_DATA);
    end

    // Main sequencer: bit capture, acknowledge window and byte hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= RX_IDLE;
            bit_cnt      <= '0;
            shreg        <= '0;
            first_pend   <= 1'b0;
            sda_pull_low <= 1'b0;
            byte_valid   <= 1'b0;
            byte_data    <= '0;
            first_byte   <= 1'b0;
            msg_end      <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            msg_end    <= 1'b0;
            if (start_det) begin
                state        <= RX_ADDR;
                bit_cnt      <= '0;
                sda_pull_low <= 1'b0;
            end else if (stop_det) begin
                msg_end      <= addressed;
                state        <= RX_IDLE;
                sda_pull_low <= 1'b0;
            end else begin
                case (state)
                    RX_ADDR, RX_DATA: begin
                        if (scl_rise && bit_cnt != FULL) begin
                            shreg   <= {shreg[BYTE_BITS-2:0], sda_bit};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == FULL) begin
                            if (state == RX_ADDR) begin
                                if (addr_hit) begin
                                    sda_pull_low <= 1'b1;
                                    first_pend   <= 1'b1;
                                    state        <= RX_ACK_ADDR;
                                end else begin
                                    state <= RX_IGNORE;
                                end
                            end else begin
                                sda_pull_low <= 1'b1;
                                byte_valid   <= 1'b1;
                                byte_data    <= shreg;
                                first_byte   <= first_pend;
                                first_pend   <= 1'b0;
                                state        <= RX_ACK_DATA;
                            end
                        end
                    end
                    RX_ACK_ADDR, RX_ACK_DATA: begin
                        if (scl_fall) begin
                            sda_pull_low <= 1'b0;
                            bit_cnt      <= '0;
                            state        <= RX_DATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == RX_ADDR && !sda_pull_low));                  // R2
    AST_ACK_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_high && $past(scl_high) && !$past(start_det || stop_det))
        |-> $stable(sda_pull_low));                                         // R4
    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IGNORE) |-> !sda_pull_low);                            // R5
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);                                        // R7
    AST_END_FOLLOWS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        msg_end |-> $past(stop_det));                                       // R9

endmodule

// File: rtl/i2c_rx_slave.sv
// Receive-only bus slave, top level.
// Cleans both bus lines, finds bus events and runs the receive controller.
// Assumes: sda_pull_low is turned into an open-drain pull on the data pad.
module i2c_rx_slave #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3,
    parameter int BYTE_BITS   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_in,
    input  logic                 sda_in,
    input  logic                 addr_strap,
    output logic                 sda_pull_low,
    output logic                 byte_valid,
    output logic [BYTE_BITS-1:0] byte_data,
    output logic                 first_byte,
    output logic                 msg_end
);
    localparam int LINES = 2;  // index 0: clock, index 1: data

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] clean_lines;
    logic scl_rise, scl_fall, start_det, stop_det;

    assign raw_lines = {sda_in, scl_in};

    // One identical cleaner per bus wire.
    for (genvar g = 0; g < LINES; g++) begin : g_clean
        i2c_rx_deglitch #(
            .SYNC_STAGES (SYNC_STAGES),
            .VOTE_TAPS   (VOTE_TAPS),
            .RESET_LEVEL (1'b1)
        ) u_clean (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (clean_lines[g])
        );
    end

    i2c_rx_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (clean_lines[0]),
        .sda_f     (clean_lines[1]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rx_ctrl #(
        .BYTE_BITS  (BYTE_BITS),
        .ADDR_FIXED ((BYTE_BITS-2)'(6'b011100))
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_high     (clean_lines[0]),
        .sda_bit      (clean_lines[1]),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .addr_strap   (addr_strap),
        .sda_pull_low (sda_pull_low),
        .byte_valid   (byte_valid),
        .byte_data    (byte_data),
        .first_byte   (first_byte),
        .msg_end      (msg_end)
    );

    AST_NO_PULL_WHEN_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> !sda_pull_low);                         // R2

endmodule

// File: tb/i2c_rx_slave_test.sv
module i2c_rx_slave_test;
    localparam int H = 20;  // system clocks per bus half-period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic strap = 1'b0;
    logic sda_pull_low, byte_valid, first_byte, msg_end;
    logic [7:0] byte_data;
    wire  sda_bus = sda_m & ~sda_pull_low;

    int vectors = 0;
    int miscompares = 0;
    int valid_cnt = 0;
    int end_cnt = 0;
    logic [7:0] last_data = '0;
    logic last_first = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    i2c_rx_slave uut (
        .clk (clk), .rst_n (rst_n), .scl_in (scl_m), .sda_in (sda_bus),
        .addr_strap (strap), .sda_pull_low (sda_pull_low),
        .byte_valid (byte_valid), .byte_data (byte_data),
        .first_byte (first_byte), .msg_end (msg_end)
    );

    // Record strobes as they arrive.
    always @(posedge clk) begin
        if (byte_valid) begin
            valid_cnt  <= valid_cnt + 1;
            last_data  <= byte_data;
            last_first <= first_byte;
        end
        if (msg_end) end_cnt <= end_cnt + 1;
    end

    // {strap, address byte, data byte, expect acknowledge}
    localparam int NV = 9;
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 8'h70, 8'hA5, 1'b1},
        {1'b1, 8'h72, 8'h3C, 1'b1},
        {1'b0, 8'h72, 8'h11, 1'b0},
        {1'b1, 8'h70, 8'h22, 1'b0},
        {1'b0, 8'h71, 8'h33, 1'b0},
        {1'b1, 8'h73, 8'h44, 1'b0},
        {1'b0, 8'hE0, 8'h55, 1'b0},
        {1'b0, 8'h70, 8'hFF, 1'b1},
        {1'b1, 8'h72, 8'h00, 1'b1}
    };

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_cyc(H);
        sda_m = 1'b0; wait_cyc(H);
        scl_m = 1'b0; wait_cyc(H);
    endtask

    task automatic bus_rep_start();
        sda_m = 1'b1; wait_cyc(H);
        scl_m = 1'b1; wait_cyc(H);
        sda_m = 1'b0; wait_cyc(H);
        scl_m = 1'b0; wait_cyc(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_cyc(H);
        scl_m = 1'b1; wait_cyc(H);
        sda_m = 1'b1; wait_cyc(H);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wait_cyc(H);
        scl_m = 1'b1; wait_cyc(H);
        scl_m = 1'b0;
    endtask

    // Eight bits MSB first, then the acknowledge clock; reports early/late
    // samples of SDA in the high phase and the pull state after it ends.
    task automatic send_byte(input logic [7:0] b, output logic ack_early,
                             output logic ack_late, output logic released);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wait_cyc(H);
        scl_m = 1'b1; wait_cyc(2);
        ack_early = ~sda_bus;
        wait_cyc(H - 3);
        ack_late = ~sda_bus;
        wait_cyc(1);
        scl_m = 1'b0; wait_cyc(H);
        released = ~sda_pull_low;
    endtask

    logic ae, al, rel;
    int v0, e0;

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        miscompares++;
        vectors++;
        $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        wait_cyc(4);
        chk(sda_pull_low == 1'b0 && byte_valid == 1'b0 && msg_end == 1'b0, "R1 reset outputs",
            {sda_pull_low, byte_valid, msg_end}, 0);
        rst_n = 1'b1;
        wait_cyc(10);

        // Table walk: one address byte and one data byte per entry.
        for (int k = 0; k < NV; k++) begin
            logic [17:0] e;
            e = VEC[k];
            strap = e[17];
            wait_cyc(5);
            v0 = valid_cnt; e0 = end_cnt;
            bus_start();
            send_byte(e[16:9], ae, al, rel);
            chk(ae == e[0] && al == e[0], e[0] ? "R3 address ack" :
                (e[9] ? "R6 read not acked" : "R5 foreign address not acked"), {ae, al}, {2{e[0]}});
            if (e[0]) chk(rel, "R4 ack released after clock", rel, 1);
            send_byte(e[8:1], ae, al, rel);
            chk(ae == e[0] && al == e[0], e[0] ? "R7 data ack" : "R5 data ignored",
                {ae, al}, {2{e[0]}});
            chk(valid_cnt - v0 == int'(e[0]), "R7 byte_valid count", valid_cnt - v0, e[0]);
            if (e[0]) chk(last_data == e[8:1] && last_first, "R7 R8 byte value and first flag",
                          {last_first, last_data}, {1'b1, e[8:1]});
            bus_stop();
            wait_cyc(10);
            chk(end_cnt - e0 == int'(e[0]), "R9 msg_end on stop", end_cnt - e0, e[0]);
        end

        // R8: three-byte message, first flag only on the first byte.
        strap = 1'b0;
        v0 = valid_cnt;
        bus_start();
        send_byte(8'h70, ae, al, rel);
        send_byte(8'h01, ae, al, rel);
        chk(last_first == 1'b1 && last_data == 8'h01, "R8 first byte flagged", {last_first, last_data}, 9'h101);
        send_byte(8'h80, ae, al, rel);
        chk(last_first == 1'b0 && last_data == 8'h80, "R8 second byte unflagged", {last_first, last_data}, 9'h080);
        send_byte(8'h6B, ae, al, rel);
        chk(ae && al && rel, "R7 third byte acked", {ae, al, rel}, 3'b111);
        chk(last_first == 1'b0 && last_data == 8'h6B && valid_cnt - v0 == 3,
            "R8 third byte unflagged", {last_first, last_data}, 9'h06B);
        bus_stop();

        // R2: repeated START in the middle of a data byte restarts addressing.
        bus_start();
        send_byte(8'h70, ae, al, rel);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_rep_start();
        send_byte(8'h70, ae, al, rel);
        chk(ae && al, "R2 address after repeated start acked", {ae, al}, 3);
        send_byte(8'h5A, ae, al, rel);
        chk(last_data == 8'h5A && last_first, "R2 byte after repeated start",
            {last_first, last_data}, 9'h15A);
        // R2: repeated START to a foreign address silences the slave.
        bus_rep_start();
        send_byte(8'h42, ae, al, rel);
        v0 = valid_cnt;
        send_byte(8'h99, ae, al, rel);
        chk(!ae && !al && valid_cnt == v0, "R2 foreign after repeated start", {ae, al}, 0);
        bus_stop();
        wait_cyc(10);

        // R10: one-cycle SDA dip with SCL high must not be a START.
        sda_m = 1'b0; wait_cyc(1); sda_m = 1'b1; wait_cyc(H);
        scl_m = 1'b0; wait_cyc(H);
        send_byte(8'h70, ae, al, rel);
        chk(!ae && !al, "R10 sda glitch not a start", {ae, al}, 0);
        scl_m = 1'b1; wait_cyc(H);
        bus_stop();

        // R10: one-cycle SCL pulse inside a low phase must not add a bit.
        bus_start();
        send_byte(8'h70, ae, al, rel);
        send_bit(1'b1); send_bit(1'b1);
        wait_cyc(H / 2); scl_m = 1'b1; wait_cyc(1); scl_m = 1'b0;
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        sda_m = 1'b1; wait_cyc(H);
        scl_m = 1'b1; wait_cyc(H); scl_m = 1'b0; wait_cyc(H);
        chk(last_data == 8'hCD, "R10 scl glitch adds no bit", last_data, 8'hCD);
        bus_stop();

        // R1: reset in the middle of a message clears the outputs.
        bus_start();
        for (int i = 0; i < 8; i++) send_bit(i == 7 ? 1'b0 : 8'h70 >> (7 - i));
        wait_cyc(H / 2);
        chk(sda_pull_low == 1'b1, "R3 ack pulled before reset", sda_pull_low, 1);
        rst_n = 1'b0; wait_cyc(2);
        chk(sda_pull_low == 1'b0 && byte_valid == 1'b0 && msg_end == 1'b0,
            "R1 reset mid-message", {sda_pull_low, byte_valid, msg_end}, 0);
        rst_n = 1'b1;
        scl_m = 1'b1; sda_m = 1'b1; wait_cyc(H);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule